// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the program counter of a 32-bit load-store processor with byte addresses and fixed-length, word-aligned instructions, and decides where the next instruction comes from. Each cycle it is offered the current instruction word together with the value already read from the register named by the instruction's `ra` field. It then presents the next program counter. For control-flow instructions it also presents a link write aimed at the destination register `rc`.

Instructions arrive on a valid/ready stream. An instruction is consumed only in a cycle where `inst_valid` and `inst_ready` are both high, and only then does the program counter move. When `inst_valid` is low, the counter holds and no link write is issued, so the upstream fetch stage can stall freely. `inst_ready` is low while reset is applied and during the first clock edge after release, and is high from then on. `next_pc` and the link outputs are combinational views of the offered instruction. `link_we` is qualified by acceptance, so a register file can write on the same edge that advances the counter.

Conditional branches test the `ra` value against zero and add a sign-extended word offset to the address of the following instruction. The register-indirect jump loads the `ra` value with its low two bits cleared. All three control instructions save the address of the following instruction, whether or not control transfers.

Top module: `pcb_branch_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0 and `inst_ready` is 0. After release, `inst_ready` is 1 from the first clock edge on, and `pc` is still 0 until the first accepted instruction.
- R2: In a cycle where `inst_valid` is 0, `pc` keeps its value across the clock edge and `link_we` is 0.
- R3: An accepted instruction whose opcode (bits [31:26]) is none of the control opcodes advances `pc` by 4, and `link_we` stays 0.
- R4: Opcode 0b011100 (branch-if-zero) is taken when `ra_value` is 0. The target is `pc`+4 plus the sign-extended 16-bit constant in bits [15:0] multiplied by 4.
- R5: Opcode 0b011101 (branch-if-nonzero) is taken when `ra_value` is non-zero, with the same target rule as R4.
- R6: A conditional branch that is not taken sets `pc` to `pc`+4.
- R7: For the three control opcodes, `link_idx` shows the `rc` field (bits [25:21]) and `link_data` is `pc`+4. `link_we` is 1 when the instruction is accepted, whatever the branch outcome.
- R8: Opcode 0b011011 (indirect jump) sets `pc` to `ra_value` with bits [1:0] forced to 0.
- R9: When `rc` is 31, the link is discarded and `link_we` stays 0.
- R10: An offset of 0 gives `pc`+4 and an offset of -1 gives the branch's own address. `pc` always has bits [1:0] equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Instruction word and ra value are offered |
| inst_ready | output | 1 | Unit can consume an instruction this cycle |
| inst_word | input | 32 | Instruction at the current `pc` |
| ra_value | input | 32 | Contents of the register named by the `ra` field |
| pc | output | 32 | Current program counter (byte address) |
| next_pc | output | 32 | Counter value taken if the offered instruction is accepted |
| link_we | output | 1 | Link write strobe to the register file |
| link_idx | output | 5 | Destination register of the link write |
| link_data | output | 32 | Return address, `pc`+4 |

## Verification
The embedded properties assume that `inst_word` and `ra_value` are meaningful only in cycles where `inst_valid` is high, and that the register file supplies `ra_value` in the same cycle as the word. The bench therefore changes both together at the falling edge and holds them through the next rising edge. The alignment property depends on the counter starting at 0, and on all branch and jump targets being built from multiples of 4 or masked. The stimulus never forces the counter by any other path, so this assumption stays true. Offsets are drawn across the full signed 16-bit range, and address wrap-around is treated as plain modulo-2^32 arithmetic on both sides.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [1:0] {
    K_SEQ = 2'd0,
    K_BZ  = 2'd1,
    K_BNZ = 2'd2,
    K_JMP = 2'd3
  } flow_kind_e;
endpackage

// File: rtl/pcb_decode.sv
module pcb_decode
  import pcb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OP_W = 6,
  parameter int IDX_W = 5,
  parameter int OFF_W = 16,
  parameter logic [OP_W-1:0] OP_BZ  = 6'b011100,
  parameter logic [OP_W-1:0] OP_BNZ = 6'b011101,
  parameter logic [OP_W-1:0] OP_JMP = 6'b011011
) (
  input  logic [XLEN-1:0]  word,
  output flow_kind_e       kind,
  output logic [IDX_W-1:0] rc_idx,
  output logic [OFF_W-1:0] offset
);
  localparam int OP_LSB = XLEN - OP_W;
  localparam int RC_LSB = OP_LSB - IDX_W;

  logic [OP_W-1:0] opcode;

  assign opcode = word[OP_LSB +: OP_W];
  assign rc_idx = word[RC_LSB +: IDX_W];
  assign offset = word[OFF_W-1:0];

  always_comb begin
    if (opcode == OP_BZ)       kind = K_BZ;
    else if (opcode == OP_BNZ) kind = K_BNZ;
    else if (opcode == OP_JMP) kind = K_JMP;
    else                       kind = K_SEQ;
  end
endmodule

// File: rtl/pcb_target.sv
module pcb_target
  import pcb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFF_W = 16,
  parameter int ALIGN_W = 2
) (
  input  flow_kind_e       kind,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  ra_val,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  tgt_pc
);
  localparam int EXT_W = XLEN - OFF_W - ALIGN_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_W;

  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] ind_pc;
  logic            ra_zero;
  logic            taken;

  assign seq_pc  = cur_pc + STEP;
  assign disp    = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN_W{1'b0}}};
  assign rel_pc  = seq_pc + disp;
  assign ind_pc  = {ra_val[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign ra_zero = (ra_val == '0);

  always_comb begin
    unique case (kind)
      K_BZ:    taken = ra_zero;
      K_BNZ:   taken = !ra_zero;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == K_JMP) tgt_pc = ind_pc;
    else if (taken)    tgt_pc = rel_pc;
    else               tgt_pc = seq_pc;
  end
endmodule

// File: rtl/pcb_link.sv
module pcb_link
  import pcb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDX_W = 5
) (
  input  logic             accept,
  input  flow_kind_e       kind,
  input  logic [IDX_W-1:0] rc_idx,
  input  logic [XLEN-1:0]  ret_addr,
  output logic             we,
  output logic [IDX_W-1:0] idx,
  output logic [XLEN-1:0]  data
);
  localparam logic [IDX_W-1:0] SINK_REG = '1;

  assign idx  = rc_idx;
  assign data = ret_addr;
  assign we   = accept && (kind != K_SEQ) && (rc_idx != SINK_REG);
endmodule

// File: rtl/pcb_branch_unit.sv
module pcb_branch_unit
  import pcb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OP_W = 6,
  parameter int IDX_W = 5,
  parameter int OFF_W = 16,
  parameter logic [OP_W-1:0] OP_BZ  = 6'b011100,
  parameter logic [OP_W-1:0] OP_BNZ = 6'b011101,
  parameter logic [OP_W-1:0] OP_JMP = 6'b011011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inst_valid,
  output logic             inst_ready,
  input  logic [XLEN-1:0]  inst_word,
  input  logic [XLEN-1:0]  ra_value,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  next_pc,
  output logic             link_we,
  output logic [IDX_W-1:0] link_idx,
  output logic [XLEN-1:0]  link_data
);
  localparam int OP_LSB = XLEN - OP_W;
  localparam int RC_LSB = OP_LSB - IDX_W;
  localparam logic [IDX_W-1:0] SINK_REG = '1;

  flow_kind_e       kind;
  logic [IDX_W-1:0] rc_idx;
  logic [OFF_W-1:0] offset;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  tgt_pc;
  logic [XLEN-1:0]  pc_q;
  logic             ready_q;
  logic             accept;

  assign accept     = inst_valid && ready_q;
  assign inst_ready = ready_q;
  assign pc         = pc_q;
  assign next_pc    = tgt_pc;

  pcb_decode #(
    .XLEN(XLEN), .OP_W(OP_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .OP_BZ(OP_BZ), .OP_BNZ(OP_BNZ), .OP_JMP(OP_JMP)
  ) u_dec (
    .word(inst_word), .kind(kind), .rc_idx(rc_idx), .offset(offset)
  );

  pcb_target #(.XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_W(2)) u_tgt (
    .kind(kind), .cur_pc(pc_q), .ra_val(ra_value), .offset(offset),
    .seq_pc(seq_pc), .tgt_pc(tgt_pc)
  );

  pcb_link #(.XLEN(XLEN), .IDX_W(IDX_W)) u_lnk (
    .accept(accept), .kind(kind), .rc_idx(rc_idx), .ret_addr(seq_pc),
    .we(link_we), .idx(link_idx), .data(link_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (accept) pc_q <= tgt_pc;
    end
  end

  logic [OP_W-1:0] op_in;
  logic            is_ctl;
  assign op_in  = inst_word[OP_LSB +: OP_W];
  assign is_ctl = (op_in == OP_BZ) || (op_in == OP_BNZ) || (op_in == OP_JMP);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |=> $stable(pc));

  a_r2_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |-> !link_we);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_ctl) |=> (pc == $past(pc) + XLEN'(4)));

  a_r6_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_in == OP_BZ && ra_value != '0) |=> (pc == $past(pc) + XLEN'(4)));

  a_r7_link: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_ctl && inst_word[RC_LSB +: IDX_W] != SINK_REG)
      |-> (link_we && link_data == pc + XLEN'(4)));

  a_r9_sink: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx != SINK_REG));

  a_r10_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);
endmodule

// File: tb/pcb_branch_unit_test.sv
module pcb_branch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] OP_BZ  = 6'b011100;
  localparam logic [5:0] OP_BNZ = 6'b011101;
  localparam logic [5:0] OP_JMP = 6'b011011;
  localparam logic [5:0] OP_ADD = 6'b100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic        inst_ready;
  logic [31:0] inst_word = '0;
  logic [31:0] ra_value = '0;
  logic [31:0] pc;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] pc_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcb_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_word(inst_word), .ra_value(ra_value), .pc(pc), .next_pc(next_pc),
    .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rc, input logic [4:0] ra, input logic [15:0] off);
    return {op, rc, ra, off};
  endfunction

  task automatic step(input logic v, input logic [31:0] w, input logic [31:0] rav);
    logic [5:0]  op;
    logic [4:0]  rc;
    logic [31:0] seq;
    logic [31:0] exp_n;
    logic        ctl;
    logic        exp_we;
    string       req;
    @(negedge clk);
    chk("R2", "pc before step", pc, pc_m);
    inst_valid = v;
    inst_word = w;
    ra_value = rav;
    #1;
    op = w[31:26];
    rc = w[25:21];
    seq = pc_m + 32'd4;
    ctl = (op == OP_BZ) || (op == OP_BNZ) || (op == OP_JMP);
    req = "R3";
    exp_n = seq;
    if (op == OP_BZ) begin
      if (rav == 0) begin exp_n = seq + {{14{w[15]}}, w[15:0], 2'b00}; req = "R4"; end
      else req = "R6";
    end else if (op == OP_BNZ) begin
      if (rav != 0) begin exp_n = seq + {{14{w[15]}}, w[15:0], 2'b00}; req = "R5"; end
      else req = "R6";
    end else if (op == OP_JMP) begin
      exp_n = {rav[31:2], 2'b00};
      req = "R8";
    end
    exp_we = v && ctl && (rc != 5'd31);
    if (v) chk(req, "next_pc", next_pc, exp_n);
    if (!v) chk("R2", "link_we idle", {31'd0, link_we}, 32'd0);
    else if (ctl && rc == 5'd31) chk("R9", "link_we sink", {31'd0, link_we}, 32'd0);
    else if (ctl) chk("R7", "link_we", {31'd0, link_we}, {31'd0, exp_we});
    else chk("R3", "link_we seq", {31'd0, link_we}, 32'd0);
    if (v && ctl) begin
      chk("R7", "link_data", link_data, seq);
      chk("R7", "link_idx", {27'd0, link_idx}, {27'd0, rc});
    end
    if (v) pc_m = exp_n;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", pc, 32'd0);
    chk("R1", "ready in reset", {31'd0, inst_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after release", {31'd0, inst_ready}, 32'd1);
    chk("R1", "pc after release", pc, 32'd0);

    step(1, mk(OP_ADD, 5'd3, 5'd1, 16'h1000), 32'h5);
    step(1, mk(OP_ADD, 5'd4, 5'd2, 16'h0), 32'h0);
    step(0, mk(OP_JMP, 5'd1, 5'd1, 16'h0), 32'h400);
    step(0, mk(OP_BZ, 5'd1, 5'd1, 16'h10), 32'h0);
    step(1, mk(OP_BZ, 5'd2, 5'd1, 16'd5), 32'h0);
    step(1, mk(OP_BZ, 5'd2, 5'd1, 16'd5), 32'h7);
    step(1, mk(OP_BNZ, 5'd6, 5'd1, 16'hfffd), 32'h1);
    step(1, mk(OP_BNZ, 5'd6, 5'd1, 16'h0040), 32'h0);
    step(1, mk(OP_BZ, 5'd7, 5'd1, 16'h0000), 32'h0);
    step(1, mk(OP_BNZ, 5'd7, 5'd1, 16'hffff), 32'h9);
    step(1, mk(OP_BZ, 5'd31, 5'd1, 16'h0003), 32'h0);
    step(1, mk(OP_JMP, 5'd28, 5'd1, 16'h0), 32'h0000_1003);
    step(1, mk(OP_JMP, 5'd31, 5'd1, 16'h0), 32'h0000_2002);
    step(1, mk(OP_BNZ, 5'd31, 5'd1, 16'h0001), 32'h0);

    for (int i = 0; i < 300; i++) begin
      logic [5:0]  op;
      logic [31:0] r;
      r = $urandom;
      case (r[1:0])
        2'd0: op = OP_BZ;
        2'd1: op = OP_BNZ;
        2'd2: op = OP_JMP;
        default: op = r[7:2];
      endcase
      step(r[8] | r[9], mk(op, r[14:10], r[19:15], $urandom), r[20] ? 32'd0 : $urandom);
    end

    @(negedge clk);
    chk("R10", "pc final", pc, pc_m);
    chk("R10", "pc aligned", {30'd0, pc[1:0]}, 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule